// File: doc/BRIEF.md
# Security Alarm Response Controller

This block gathers the tamper and fault alarms raised by on-chip sensors and monitors and decides how the chip responds to each one. Alarms fall into two classes.

The fatal class covers environmental, probing and integrity alarms. A fatal alarm stops the system and raises reset requests toward the reset generator. The block stays in that state until the chip sees a power-on reset. While it is stopped, a write-inhibit output guards the non-volatile memory.

The recoverable class covers two events: an uncorrectable multi-bit memory error and an undefined-instruction event. These are passed to software. The memory error goes to a maskable interrupt line, and the undefined-instruction event goes to a non-maskable interrupt line.

Every cause is recorded in a sticky status word that software can read. Software clears the recoverable causes with a write-one-to-clear access. The fatal causes can only be cleared by power-on reset.

The alarm inputs are asynchronous to the block clock, so each one passes through a two-flop synchronizer. The power-on reset `rst_n` is asserted asynchronously and released in step with the clock.

Top module: `alarm_ctrl`

## Requirements
- R1: When fatal alarm input `halt_alarm_i[i]` is high across one rising clock edge, `halt_o` and `status_o[i]` are high after the third rising edge counted from that edge, and not after the second.
- R2: Once high, `halt_o` and every set fatal bit in `status_o[N_HALT-1:0]` stay high until `rst_n` goes low. Dropping the alarm input does not lower them, and neither does a clear write.
- R3: `rst_req_o[0]` requests reset of the RF interface and the coprocessor. It is high while any latched fatal cause with index 0 to 5 is set (mask 10'h03F). `rst_req_o[1]` requests reset of the CPU. It is high while any latched fatal cause with index 4 to 9 is set (mask 10'h3F0). Both bits take effect in the same cycle as `halt_o`.
- R4: `nv_wr_inhibit_o` is high in exactly the cycles in which `halt_o` is high.
- R5: An uncorrectable memory error (`ecc_err_i`) sets `status_o[N_HALT]` after the same three-edge latency as R1. While the block is not halted, `irq_o` then goes high.
- R6: An undefined-instruction event (`undef_evt_i`) sets `status_o[N_HALT+1]` after the same three-edge latency as R1. While the block is not halted, `nmi_o` then goes high.
- R7: A cycle with `clr_we_i` high clears `status_o[N_HALT]` and `status_o[N_HALT+1]` at the next edge wherever the matching `clr_mask_i` bit is 1. Bits whose mask bit is 0 are untouched. If a synchronized event arrives at the same edge as its clear, the set wins.
- R8: When a fatal event and a recoverable event reach the cause logic at the same edge, only the fatal one is recorded. While halted, no new recoverable cause is recorded, and `irq_o` and `nmi_o` are low.
- R9: After reset, `halt_o`, `nv_wr_inhibit_o`, `rst_req_o`, `irq_o`, `nmi_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| halt_alarm_i | input | N_HALT | Fatal-class alarm inputs, asynchronous |
| ecc_err_i | input | 1 | Uncorrectable multi-bit memory error, asynchronous |
| undef_evt_i | input | 1 | Undefined-instruction event, asynchronous |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | N_HALT+2 | Write-one-to-clear mask aligned to `status_o` |
| halt_o | output | 1 | System halt |
| nv_wr_inhibit_o | output | 1 | Non-volatile memory write inhibit |
| rst_req_o | output | 2 | Reset requests: bit 0 RF and coprocessor, bit 1 CPU |
| irq_o | output | 1 | Maskable interrupt for memory errors |
| nmi_o | output | 1 | Non-maskable interrupt for undefined instructions |
| status_o | output | N_HALT+2 | Sticky causes: fatal bits, then memory error, then undefined instruction |

## Verification
The bench first walks each fatal input on its own. This exposes a wrong reset-target mask, or a synchronizer that is one stage short and so reports one cycle early.

It then drives a fatal and a recoverable event together. A design without the override would record a pending interrupt that software would later see on a halted system.

A clear write is issued while the event is still present, and a clear is also aimed at the fatal bits. A design that lets the clear win would lose a live event. A design whose clear reaches the fatal bits would forget why it halted.

Finally, the bench checks that the halt outlives the alarm and ends only with power-on reset. A latch that followed its input would resume operation on its own.

// File: rtl/alarm_ctrl_pkg.sv
package alarm_ctrl_pkg;

  // Positions of the two reset-request targets.
  typedef enum int unsigned {
    RST_TGT_PERIPH = 0,
    RST_TGT_CPU    = 1
  } rst_tgt_e;

  localparam int unsigned NUM_RST_TGT = 2;

  // Positions of the recoverable causes above the fatal bits.
  typedef enum int unsigned {
    INT_ECC   = 0,
    INT_UNDEF = 1
  } int_cause_e;

  localparam int unsigned NUM_INT = 2;

endpackage

// File: rtl/alarm_ctrl_rst_sync.sv
module alarm_ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/alarm_ctrl_sync.sv
module alarm_ctrl_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[b];
        stable_q <= meta_q;
      end
    end

    assign sync_o[b] = stable_q;
  end

endmodule

// File: rtl/alarm_ctrl_halt.sv
module alarm_ctrl_halt
  import alarm_ctrl_pkg::*;
#(
  parameter int unsigned          N_HALT      = 10,
  parameter logic [N_HALT-1:0]    PERIPH_MASK = '1,
  parameter logic [N_HALT-1:0]    CPU_MASK    = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_HALT-1:0]      evt_i,
  output logic                   halt_q_o,
  output logic [N_HALT-1:0]      cause_q_o,
  output logic [NUM_RST_TGT-1:0] rst_req_o
);

  localparam logic [N_HALT-1:0] TGT_MASK [NUM_RST_TGT] = '{PERIPH_MASK, CPU_MASK};

  logic                   halt_q,  halt_d;
  logic [N_HALT-1:0]      cause_q, cause_d;
  logic [NUM_RST_TGT-1:0] req_q,   req_d;
  logic                   upd_en;

  // Any fatal event opens the register enable; nothing ever closes a bit.
  always_comb begin
    upd_en  = |evt_i;
    cause_d = cause_q | evt_i;
    halt_d  = halt_q | (|evt_i);
  end

  for (genvar t = 0; t < NUM_RST_TGT; t++) begin : g_tgt
    always_comb begin
      req_d[t] = |(cause_d & TGT_MASK[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      cause_q <= '0;
      req_q   <= '0;
    end else if (upd_en) begin
      halt_q  <= halt_d;
      cause_q <= cause_d;
      req_q   <= req_d;
    end
  end

  assign halt_q_o  = halt_q;
  assign cause_q_o = cause_q;
  assign rst_req_o = req_q;

endmodule

// File: rtl/alarm_ctrl_irq.sv
module alarm_ctrl_irq
  import alarm_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] evt_i,
  input  logic               block_i,
  input  logic               clr_we_i,
  input  logic [NUM_INT-1:0] clr_mask_i,
  output logic [NUM_INT-1:0] pend_q_o
);

  logic [NUM_INT-1:0] pend_q, pend_d;
  logic               upd_en;

  for (genvar k = 0; k < NUM_INT; k++) begin : g_cause
    logic set_k;
    logic clr_k;

    always_comb begin
      set_k     = evt_i[k] & ~block_i;
      clr_k     = clr_we_i & clr_mask_i[k];
      pend_d[k] = set_k | (pend_q[k] & ~clr_k);
    end
  end

  always_comb begin
    upd_en = clr_we_i | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_q_o = pend_q;

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_ctrl_pkg::*;
#(
  parameter int unsigned       N_HALT          = 10,
  parameter logic [N_HALT-1:0] PERIPH_RST_MASK = 10'h03F,
  parameter logic [N_HALT-1:0] CPU_RST_MASK    = 10'h3F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HALT-1:0] halt_alarm_i,
  input  logic              ecc_err_i,
  input  logic              undef_evt_i,
  input  logic              clr_we_i,
  input  logic [N_HALT+1:0] clr_mask_i,
  output logic              halt_o,
  output logic              nv_wr_inhibit_o,
  output logic [1:0]        rst_req_o,
  output logic              irq_o,
  output logic              nmi_o,
  output logic [N_HALT+1:0] status_o
);

  localparam int unsigned SYNC_W = N_HALT + NUM_INT;

  logic               rst_core_n;
  logic [SYNC_W-1:0]  raw_in;
  logic [SYNC_W-1:0]  syn_in;
  logic [N_HALT-1:0]  halt_evt;
  logic [NUM_INT-1:0] int_evt;
  logic               halt_q;
  logic [N_HALT-1:0]  halt_cause;
  logic [NUM_INT-1:0] int_pend;
  logic               int_block;

  alarm_ctrl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // All asynchronous sources share one synchronizer bank.
  always_comb begin
    raw_in                      = '0;
    raw_in[N_HALT-1:0]          = halt_alarm_i;
    raw_in[N_HALT + INT_ECC]    = ecc_err_i;
    raw_in[N_HALT + INT_UNDEF]  = undef_evt_i;
  end

  alarm_ctrl_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  assign halt_evt = syn_in[N_HALT-1:0];
  assign int_evt  = syn_in[SYNC_W-1:N_HALT];

  alarm_ctrl_halt #(
    .N_HALT      (N_HALT),
    .PERIPH_MASK (PERIPH_RST_MASK),
    .CPU_MASK    (CPU_RST_MASK)
  ) u_halt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .evt_i     (halt_evt),
    .halt_q_o  (halt_q),
    .cause_q_o (halt_cause),
    .rst_req_o (rst_req_o)
  );

  // Fatal class wins: a fatal event at this edge or an existing halt
  // keeps recoverable causes from being recorded.
  always_comb begin
    int_block = halt_q | (|halt_evt);
  end

  alarm_ctrl_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .evt_i      (int_evt),
    .block_i    (int_block),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i[SYNC_W-1:N_HALT]),
    .pend_q_o   (int_pend)
  );

  always_comb begin
    halt_o          = halt_q;
    nv_wr_inhibit_o = halt_q;
    irq_o           = int_pend[INT_ECC]   & ~halt_q;
    nmi_o           = int_pend[INT_UNDEF] & ~halt_q;
    status_o        = {int_pend, halt_cause};
  end

endmodule

// File: rtl/alarm_ctrl_chk.sv
module alarm_ctrl_chk #(
  parameter int unsigned N_HALT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_o,
  input logic [1:0]        rst_req_o,
  input logic [N_HALT+1:0] status_o
);

  // R2: the halt never releases on its own.
  assert_halt_sticky_R2: assert property (
    @(posedge clk) disable iff (!rst_n) halt_o |=> halt_o);

  // R2: no latched fatal cause is ever lost.
  assert_halt_cause_kept_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      ((status_o[N_HALT-1:0] & $past(status_o[N_HALT-1:0])) == $past(status_o[N_HALT-1:0])));

  // R1: the halt register and the cause register agree.
  assert_halt_has_cause_R1: assert property (
    @(posedge clk) disable iff (!rst_n) halt_o == (|status_o[N_HALT-1:0]));

  // R3: reset requests only ever accompany a halt.
  assert_rst_req_needs_halt_R3: assert property (
    @(posedge clk) disable iff (!rst_n) (|rst_req_o) |-> halt_o);

  // R8: no memory-error cause is recorded while halted.
  assert_no_ecc_when_halted_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (halt_o && !status_o[N_HALT]) |=> !status_o[N_HALT]);

  // R8: no undefined-instruction cause is recorded while halted.
  assert_no_undef_when_halted_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (halt_o && !status_o[N_HALT+1]) |=> !status_o[N_HALT+1]);

endmodule

bind alarm_ctrl alarm_ctrl_chk #(.N_HALT(N_HALT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halt_o    (halt_o),
  .rst_req_o (rst_req_o),
  .status_o  (status_o)
);

// File: tb/alarm_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_ctrl_tb;

  localparam int NH = 10;
  localparam logic [NH-1:0] M_PERIPH = 10'h03F;
  localparam logic [NH-1:0] M_CPU    = 10'h3F0;

  // Vector fields: [6] ecc, [5] undef, [4] clr_we, [3:2] clr mask {undef,ecc},
  // [1] expected irq, [0] expected nmi.
  localparam int NV = 8;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_0_00_1_0,
    7'b0_0_0_00_1_0,
    7'b0_0_1_01_0_0,
    7'b0_1_0_00_0_1,
    7'b0_0_1_01_0_1,
    7'b1_0_1_10_1_0,
    7'b1_0_1_01_1_0,
    7'b0_0_1_11_0_0
  };

  logic          clk;
  logic          rst_n;
  logic [NH-1:0] halt_alarm_i;
  logic          ecc_err_i;
  logic          undef_evt_i;
  logic          clr_we_i;
  logic [NH+1:0] clr_mask_i;
  logic          halt_o;
  logic          nv_wr_inhibit_o;
  logic [1:0]    rst_req_o;
  logic          irq_o;
  logic          nmi_o;
  logic [NH+1:0] status_o;

  int n_chk;
  int n_bad;

  alarm_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .halt_alarm_i    (halt_alarm_i),
    .ecc_err_i       (ecc_err_i),
    .undef_evt_i     (undef_evt_i),
    .clr_we_i        (clr_we_i),
    .clr_mask_i      (clr_mask_i),
    .halt_o          (halt_o),
    .nv_wr_inhibit_o (nv_wr_inhibit_o),
    .rst_req_o       (rst_req_o),
    .irq_o           (irq_o),
    .nmi_o           (nmi_o),
    .status_o        (status_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n        = 1'b0;
    halt_alarm_i = '0;
    ecc_err_i    = 1'b0;
    undef_evt_i  = 1'b0;
    clr_we_i     = 1'b0;
    clr_mask_i   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wipe(input logic [NH+1:0] m);
    clr_we_i   = 1'b1;
    clr_mask_i = m;
    @(posedge clk);
    @(negedge clk);
    clr_we_i   = 1'b0;
    clr_mask_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;

    // R9: reset state
    do_reset();
    chk("R9 halt", 32'(halt_o), 0);
    chk("R9 inhibit", 32'(nv_wr_inhibit_o), 0);
    chk("R9 rst_req", 32'(rst_req_o), 0);
    chk("R9 irq/nmi", 32'({irq_o, nmi_o}), 0);
    chk("R9 status", 32'(status_o), 0);

    // R5 R6 R7: recoverable causes, table driven
    for (int v = 0; v < NV; v++) begin
      ecc_err_i   = VEC[v][6];
      undef_evt_i = VEC[v][5];
      repeat (3) @(posedge clk);
      @(negedge clk);
      clr_we_i   = VEC[v][4];
      clr_mask_i = {VEC[v][3:2], {NH{1'b0}}};
      @(posedge clk);
      @(negedge clk);
      clr_we_i   = 1'b0;
      clr_mask_i = '0;
      chk($sformatf("R5 irq vec%0d", v), 32'(irq_o), 32'(VEC[v][1]));
      chk($sformatf("R6 nmi vec%0d", v), 32'(nmi_o), 32'(VEC[v][0]));
      chk($sformatf("R7 status vec%0d", v), 32'(status_o), 32'({VEC[v][0], VEC[v][1], {NH{1'b0}}}));
    end

    // R1 R3 R4: each fatal input alone, one-cycle pulse
    for (int i = 0; i < NH; i++) begin
      logic [NH-1:0] one;
      one = NH'(1) << i;
      do_reset();
      halt_alarm_i = one;
      @(posedge clk);
      @(negedge clk);
      halt_alarm_i = '0;
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1 early halt in%0d", i), 32'(halt_o), 0);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1 halt in%0d", i), 32'(halt_o), 1);
      chk($sformatf("R1 status in%0d", i), 32'(status_o), 32'(one));
      chk($sformatf("R3 rst_req in%0d", i), 32'(rst_req_o),
          32'({|(one & M_CPU), |(one & M_PERIPH)}));
      chk($sformatf("R4 inhibit in%0d", i), 32'(nv_wr_inhibit_o), 1);
    end

    // R8: fatal and recoverable arriving together
    do_reset();
    halt_alarm_i = NH'(1) << 1;
    ecc_err_i    = 1'b1;
    undef_evt_i  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 same-edge status", 32'(status_o), 32'(NH'(1) << 1));
    chk("R8 same-edge irq/nmi", 32'({irq_o, nmi_o}), 0);

    // R8: cause pending before halt is masked at the outputs
    do_reset();
    ecc_err_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ecc_err_i = 1'b0;
    chk("R5 irq before halt", 32'(irq_o), 1);
    halt_alarm_i = NH'(1) << 8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 irq masked while halted", 32'(irq_o), 0);
    chk("R3 cpu only", 32'(rst_req_o), 32'(2'b10));
    chk("R4 inhibit on", 32'(nv_wr_inhibit_o), 1);

    // R2: release the alarm, try to clear everything
    halt_alarm_i = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    wipe('1);
    chk("R2 halt kept", 32'(halt_o), 1);
    chk("R2 fatal bit kept", 32'(status_o[NH-1:0]), 32'(NH'(1) << 8));
    chk("R7 ecc cleared while halted", 32'(status_o[NH]), 0);

    // R8: new recoverable event ignored while halted
    undef_evt_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 undef not recorded", 32'(status_o[NH+1]), 0);
    chk("R8 nmi low", 32'(nmi_o), 0);

    // R2: only power-on reset resumes
    do_reset();
    chk("R2 halt gone after reset", 32'(halt_o), 0);
    chk("R2 status gone after reset", 32'(status_o), 0);
    chk("R4 inhibit off", 32'(nv_wr_inhibit_o), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule